// File: doc/BRIEF.md
# Serial Conversion Port for a Four-Channel Sensing Converter

This block is the digital side of a sensing converter that a host reaches over a four-wire serial link. The host pulls the active-low select line down, toggles the serial clock sixteen times, and on every falling clock edge one bit moves in each direction. The block sends a sixteen-bit result word. It also takes in a twelve-bit control word that chooses which of four parallel 12-bit sample inputs is reported and how that sample is coded.

The block runs on a fast system clock. The serial clock, the select line and the data input are brought through synchronizers, and edges are found by comparing successive synchronized values. The control word is pipelined: a selection written in one frame governs the result of the frame after it. The channel hold register switches to the new channel at the fourteenth falling edge, so the next result is captured there. A frame that the host cuts short by raising select early leaves the control state untouched. The serial output comes with an enable for an external three-state driver.

Top module: `spi_conv_port`

## Requirements
- R1: After reset the output enable is low, the data output is low, and the control state selects channel code 00 with straight-binary coding.
- R2: The result word is sent most significant bit first. Bit 15 is on the data output once select has fallen, and each later bit follows one falling edge of the serial clock. Bits 15:14 are 0, bits 13:12 carry the channel code of the reported sample, and bits 11:0 carry the coded sample.
- R3: The output enable rises after select falls and drops after the sixteenth falling edge. It is low whenever select has been high for a few system clocks.
- R4: The data input is sampled on the first twelve falling edges, most significant bit first, as control bits 11 down to 0. If bit 11 is 1, bits 7:6 (channel code) and bit 0 (coding) are loaded at the end of the frame. If bit 11 is 0, the control state stays as it was.
- R5: Channel code 00 reports the rate input, 01 the temperature input, 10 the first auxiliary input and 11 the second auxiliary input.
- R6: With coding bit 1 the sample is sent unchanged (straight binary). With coding bit 0 its most significant bit is inverted (twos complement).
- R7: A control word takes effect in the frame after the one that carried it, and not in the frame that carried it.
- R8: Data input values during falling edges 13 to 16 have no effect.
- R9: If select rises before the sixteenth falling edge, the output enable drops and the control state is not updated.
- R10: After a complete frame, the next result is the sample that the newly selected channel held at the fourteenth falling edge. After reset, or after a cut-short frame, the next result is the current sample of the selected channel taken when select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial control data from host |
| rate_smp | input | DATA_W | Rate channel sample, straight binary |
| temp_smp | input | DATA_W | Temperature channel sample |
| aux1_smp | input | DATA_W | First auxiliary channel sample |
| aux2_smp | input | DATA_W | Second auxiliary channel sample |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Enable for the external three-state output driver |

## Verification
The bench first writes a control word with the write bit cleared. A design that ignored that bit would switch channel one frame early. The bench then changes every sample input right after the fourteenth edge of a writing frame. A design that sampled at select-fall instead of at the fourteenth edge would report the changed value. Cut-short frames are run both before and after the fourteenth edge. A design that committed early, or that reused a hold taken in a cut-short frame, would report the wrong channel or a stale sample. Trailing data-input bits are driven with patterns that would corrupt the write bit or the channel field if the receive shifter ran past twelve bits. Both codings are used on samples whose top bit is 0 and on samples whose top bit is 1.

// File: rtl/spi_conv_pkg.sv
package spi_conv_pkg;
  localparam int CH_ADDR_W    = 2;
  localparam int CFG_CHAN_LSB = 6;
  localparam int CFG_CODE_BIT = 0;

  typedef struct packed {
    logic [CH_ADDR_W-1:0] chan;
    logic                 straight;
  } conv_cfg_t;

  localparam conv_cfg_t CFG_AT_RESET = '{chan: '0, straight: 1'b1};
endpackage

// File: rtl/spi_conv_sync.sv
module spi_conv_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/spi_conv_sample_sel.sv
module spi_conv_sample_sel #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  parameter int SEL_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0][DATA_W-1:0] samples,
  input  logic [SEL_W-1:0]              sel,
  output logic [DATA_W-1:0]             raw
);
  always_comb begin
    raw = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel == SEL_W'(c)) raw = samples[c];
    end
  end
endmodule

// File: rtl/spi_conv_frame.sv
module spi_conv_frame
  import spi_conv_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CTRL_W      = 12,
  parameter int FRAME_LEN   = 16,
  parameter int SWITCH_EDGE = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_s,
  input  logic                 cs_n_s,
  input  logic                 din_s,
  input  logic [DATA_W-1:0]    raw_smp,
  output logic [CH_ADDR_W-1:0] mux_sel,
  output logic                 dout,
  output logic                 dout_oe
);
  localparam int PAD_W = FRAME_LEN - DATA_W - CH_ADDR_W;
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] HOLD_IDX = CNT_W'(SWITCH_EDGE - 1);
  localparam logic [CNT_W-1:0] RX_LEN   = CNT_W'(CTRL_W);

  function automatic logic [DATA_W-1:0] code_sample(input logic [DATA_W-1:0] r,
                                                     input logic straight);
    return straight ? r : {~r[DATA_W-1], r[DATA_W-2:0]};
  endfunction

  logic                 sclk_q, cs_q;
  logic                 sclk_fall, cs_fall, cs_rise;
  logic                 active;
  logic [CNT_W-1:0]     cnt;
  logic [CTRL_W-1:0]    rx;
  logic [FRAME_LEN-1:0] tx;
  logic [FRAME_LEN-1:0] frame_word;
  conv_cfg_t            ctrl_q, rx_cfg;
  logic                 rx_wr;
  logic [DATA_W-1:0]    held;
  logic                 held_ok;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign cs_fall   = cs_q & ~cs_n_s;
  assign cs_rise   = ~cs_q & cs_n_s;

  always_comb begin
    rx_wr           = rx[CTRL_W-1];
    rx_cfg.chan     = rx[CFG_CHAN_LSB +: CH_ADDR_W];
    rx_cfg.straight = rx[CFG_CODE_BIT];
  end

  // Once the control word is complete, the hold mux follows the pending selection.
  assign mux_sel = (active && cnt >= RX_LEN && rx_wr) ? rx_cfg.chan : ctrl_q.chan;

  assign frame_word = {{PAD_W{1'b0}}, ctrl_q.chan,
                       code_sample(held_ok ? held : raw_smp, ctrl_q.straight)};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b1;
      cs_q    <= 1'b1;
      active  <= 1'b0;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      dout_oe <= 1'b0;
      ctrl_q  <= CFG_AT_RESET;
      held    <= '0;
      held_ok <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      if (cs_fall) begin
        active  <= 1'b1;
        cnt     <= '0;
        tx      <= frame_word;
        dout_oe <= 1'b1;
        held_ok <= 1'b0;
      end else if (active) begin
        if (cs_rise) begin
          active  <= 1'b0;
          dout_oe <= 1'b0;
          tx      <= '0;
        end else if (sclk_fall) begin
          cnt <= cnt + 1'b1;
          tx  <= {tx[FRAME_LEN-2:0], 1'b0};
          if (cnt < RX_LEN) rx <= {rx[CTRL_W-2:0], din_s};
          if (cnt == HOLD_IDX) held <= raw_smp;
          if (cnt == LAST_IDX) begin
            active  <= 1'b0;
            dout_oe <= 1'b0;
            held_ok <= 1'b1;
            if (rx_wr) ctrl_q <= rx_cfg;
          end
        end
      end
    end
  end

  assign dout = tx[FRAME_LEN-1];

  // R3: a deselected port stops driving
  a_r3_oe_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && cs_q) |=> !dout_oe);
  // R3: a select fall turns the driver on
  a_r3_oe_on_at_start: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> dout_oe);
  // R2: the first bit of every result word is zero
  a_r2_lead_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> !dout);
  // R9: a cut-short frame leaves the control state alone
  a_r9_abort_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    (active && cs_rise) |=> $stable(ctrl_q));
  // R7: control state moves only on the last falling edge of a frame
  a_r7_ctrl_moves_at_end_only: assert property (@(posedge clk) disable iff (rst)
    !(active && !cs_rise && !cs_fall && sclk_fall && cnt == LAST_IDX) |=> $stable(ctrl_q));
  // R10: the hold flag is set only after a complete frame
  a_r10_hold_after_full_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(held_ok) |-> $fell(dout_oe));
endmodule

// File: rtl/spi_conv_port.sv
module spi_conv_port
  import spi_conv_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 12,
  parameter int FRAME_LEN   = 16,
  parameter int SWITCH_EDGE = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic [DATA_W-1:0] rate_smp,
  input  logic [DATA_W-1:0] temp_smp,
  input  logic [DATA_W-1:0] aux1_smp,
  input  logic [DATA_W-1:0] aux2_smp,
  output logic              dout,
  output logic              dout_oe
);
  localparam int NUM_CH = 4;

  logic [2:0]                   pins_s;
  logic [NUM_CH-1:0][DATA_W-1:0] samples;
  logic [CH_ADDR_W-1:0]         mux_sel;
  logic [DATA_W-1:0]            raw_smp;

  // R5: channel code order
  assign samples[0] = rate_smp;
  assign samples[1] = temp_smp;
  assign samples[2] = aux1_smp;
  assign samples[3] = aux2_smp;

  spi_conv_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b110)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in({sclk, cs_n, din}),
    .sync_out(pins_s)
  );

  spi_conv_sample_sel #(
    .DATA_W(DATA_W),
    .NUM_CH(NUM_CH),
    .SEL_W (CH_ADDR_W)
  ) u_sel (
    .samples(samples),
    .sel    (mux_sel),
    .raw    (raw_smp)
  );

  spi_conv_frame #(
    .DATA_W     (DATA_W),
    .CTRL_W     (CTRL_W),
    .FRAME_LEN  (FRAME_LEN),
    .SWITCH_EDGE(SWITCH_EDGE)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (pins_s[2]),
    .cs_n_s (pins_s[1]),
    .din_s  (pins_s[0]),
    .raw_smp(raw_smp),
    .mux_sel(mux_sel),
    .dout   (dout),
    .dout_oe(dout_oe)
  );
endmodule

// File: tb/spi_conv_port_bench.sv
module spi_conv_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic [11:0] smp [4];
  logic [11:0] nsmp [4];
  logic dout, dout_oe;

  int checks = 0, errors = 0, hi_run = 0;
  bit late_chg = 1'b0;

  // reference state
  logic [1:0]  m_chan = 2'b00;
  logic        m_straight = 1'b1;
  logic [11:0] m_held = '0;
  bit          m_held_ok = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_conv_port u_spi_conv_port (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .rate_smp(smp[0]), .temp_smp(smp[1]), .aux1_smp(smp[2]), .aux2_smp(smp[3]),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R3 every clock: driver off when select has been high for a while
  always @(negedge clk) begin
    if (rst || !cs_n) hi_run = 0;
    else hi_run++;
    if (hi_run >= 4) chk("R3 idle enable", 32'(dout_oe), 32'd0);
  end

  task automatic frame(input string tag, input logic [15:0] dword, input int nfalls);
    logic [11:0] raw, coded;
    logic [15:0] exp, got, mask;
    logic [1:0]  acq;
    raw   = m_held_ok ? m_held : smp[m_chan];
    coded = m_straight ? raw : {~raw[11], raw[10:0]};
    exp   = {2'b00, m_chan, coded};
    m_held_ok = 1'b0;
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk({tag, " R3 enable at start"}, 32'(dout_oe), 32'd1);
    got[15] = dout;
    for (int i = 0; i < nfalls; i++) begin
      din = dword[15-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 15) got[14-i] = dout;
      if (i == 15) chk({tag, " R3 enable after 16th edge"}, 32'(dout_oe), 32'd0);
      if (i == 13) begin
        acq = dword[15] ? dword[11:10] : m_chan;
        m_held = smp[acq];
        if (late_chg) for (int c = 0; c < 4; c++) smp[c] = nsmp[c];
      end
      sclk = 1'b1;
    end
    mask = (nfalls >= 15) ? 16'hFFFF : ~(16'hFFFF >> (nfalls + 1));
    chk({tag, " R2 result word"}, 32'(got & mask), 32'(exp & mask));
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; din = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R9 enable after select high"}, 32'(dout_oe), 32'd0);
    if (nfalls >= 16) begin
      if (dword[15]) begin m_chan = dword[11:10]; m_straight = dword[4]; end
      m_held_ok = 1'b1;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    smp[0] = 12'h5A3; smp[1] = 12'h9C4; smp[2] = 12'h3E1; smp[3] = 12'hB07;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset enable", 32'(dout_oe), 32'd0);
    chk("R1 reset data", 32'(dout), 32'd0);
    // R1 R5: reset config reports rate straight; load temp, twos (0x870), trailing ones R8
    frame("R1 R5", {12'h870, 4'hF}, 16);
    // R6 R7: temp twos now; write bit clear (0x0F1) must not change config R4
    frame("R6 R7", {12'h0F1, 4'h0}, 16);
    // R4: still temp twos; write aux1 straight (0x8B1); samples change after 14th edge R10
    nsmp[0] = 12'h111; nsmp[1] = 12'h222; nsmp[2] = 12'h8F3; nsmp[3] = 12'h7AA;
    late_chg = 1'b1;
    frame("R4", {12'h8B1, 4'hA}, 16);
    late_chg = 1'b0;
    // R10: reports held aux1; then write aux2 twos cut after 8 edges R9
    frame("R10 held", {12'h8F0, 4'h5}, 8);
    // R9: config kept (aux1 straight), live sample; load aux2 twos, trailing 1010 R8
    frame("R9 kept", {12'h8F0, 4'hA}, 16);
    // R8 R6: aux2 twos; write rate straight but cut after 15 edges
    frame("R8 R6", {12'h831, 4'hF}, 15);
    // R9: still aux2 live sample; load rate straight
    frame("R9 late cut", {12'h831, 4'h0}, 16);
    // R5: rate straight; load aux1 twos
    frame("R5 rate", {12'h8B0, 4'hF}, 16);
    // R6: aux1 twos on a sample with top bit set
    frame("R6 aux1", {12'h000, 4'h0}, 16);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule